// File: doc/BRIEF.md
# SDRAM Window Shadow Save Port

This block keeps a block-RAM copy of one aligned window of SDRAM word space, so that the window can be saved to removable storage and loaded back later. It watches the 16-bit write traffic going to the SDRAM, meaning the word address, the data, the two byte enables and the write strobe. Every write that lands inside the window is copied into local RAM, and only the enabled bytes are updated. Writes outside the window do not touch the copy.

The save side is byte-wide and has no read strobe. The host firmware raises a save flag, presents a byte address and expects the matching byte on the output. The host may step the address at any rate, so the data always comes from the local copy and never from the SDRAM. The same flag means something else while a download is running. The host is then sending previously saved bytes into the core, and each strobed byte is written into the copy.

The window starts at word address `BASE`, which must be a multiple of 2^`LEN`, and holds 2^`LEN` words. With `LEN` = 10 that is 1024 words, seen as 2048 bytes on the save side. The total save image must stay under 64 kB, so `LEN` must be 14 or less.

Top module: `sdram_shadow_dump`

## Requirements
- R1: After a synchronous reset, `dump_data` reads 0 until the first readout.
- R2: An SDRAM write with `sd_we` high and `BASE <= sd_waddr < BASE + 2^LEN` stores the word at index `sd_waddr - BASE` of the copy.
- R3: `sd_wbe[0]` enables the low byte (`sd_wdata[7:0]`) and `sd_wbe[1]` enables the high byte (`sd_wdata[15:8]`). A byte whose enable is low keeps its old value.
- R4: An SDRAM write outside the window, or any cycle with `sd_we` low, leaves the copy unchanged.
- R5: While `save_act` = 1 and `dl_active` = 0 (readout), `dump_data` shows, one cycle later, the byte at `host_addr`. Bit 0 of `host_addr` selects the low byte (0) or the high byte (1), and bits `LEN:1` index the word. This holds with a new address on every cycle.
- R6: While `save_act` = 1 and `dl_active` = 1 (restore), a cycle with `host_wr` high writes `host_wdata` into the byte at `host_addr`, and `dump_data` holds its value.
- R7: If a restore write and an SDRAM window write fall in the same cycle, only the restore write takes effect.
- R8: Whenever readout is not active, `dump_data` keeps its last value.
- R9: If a readout and an SDRAM write hit the same word in the same cycle, `dump_data` shows the old byte first and shows the new byte on the next readout cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_we | input | 1 | SDRAM write strobe being snooped |
| sd_waddr | input | AW (22) | SDRAM word address |
| sd_wdata | input | 16 | SDRAM write data |
| sd_wbe | input | 2 | Byte enables, bit 1 = high byte |
| save_act | input | 1 | Save port active flag |
| dl_active | input | 1 | Download in progress; with save_act it selects restore |
| host_wr | input | 1 | Restore byte strobe |
| host_addr | input | LEN+1 (11) | Byte address into the window |
| host_wdata | input | 8 | Restore byte |
| dump_data | output | 8 | Readout byte, registered |

## Verification
Checks that run on every cycle cover the write side. A snooped write outside the window, or with the strobe low, produces no RAM write enable. A write inside the window enables exactly the lanes in `sd_wbe`. A restore write enables only the lane chosen by address bit 0 and takes priority over a snooped write. The output holds whenever readout is off and is zero right after reset. Whether the stored bytes are the right ones can only be seen in the bench scenarios. These fill the whole window by restore, apply a table of snooped writes inside, at the edges of and outside the window, and read every byte back with the address changing each cycle. Further scenarios cover a restore write colliding with a snooped write, and a readout colliding with a write to the same word.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int LANES  = 2;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // one write command into the lane RAMs
    typedef struct packed {
        logic [LANES-1:0]  en;
        byte_t [LANES-1:0] data;
    } lane_wr_t;

    typedef enum logic [1:0] {
        PORT_IDLE    = 2'd0,
        PORT_DUMP    = 2'd1,
        PORT_RESTORE = 2'd2
    } port_mode_t;

    function automatic port_mode_t port_mode(input logic act, input logic dl);
        if (!act) return PORT_IDLE;
        if (dl)   return PORT_RESTORE;
        return PORT_DUMP;
    endfunction

    function automatic logic [LANES-1:0] lane_onehot(input logic sel);
        return sel ? 2'b10 : 2'b01;
    endfunction

    function automatic byte_t pick_lane(input byte_t [LANES-1:0] w, input logic sel);
        return w[sel];
    endfunction
endpackage

// File: rtl/shadow_snoop.sv
module shadow_snoop
    import shadow_pkg::*;
#(
    parameter int          AW   = 22,
    parameter int          LEN  = 10,
    parameter int unsigned BASE = 'h10_0000
) (
    input  logic                      sd_we,
    input  logic [AW-1:0]             sd_waddr,
    input  logic [LANES*BYTE_W-1:0]   sd_wdata,
    input  logic [LANES-1:0]          sd_wbe,
    output lane_wr_t                  snp,
    output logic [LEN-1:0]            snp_idx
);
    localparam int HW = AW - LEN;
    localparam logic [HW-1:0] BASE_HI = HW'(BASE >> LEN);

    logic hit;

    always_comb begin
        hit      = sd_we && (sd_waddr[AW-1:LEN] == BASE_HI);
        snp.en   = hit ? sd_wbe : '0;
        snp.data = sd_wdata;
        snp_idx  = sd_waddr[LEN-1:0];
    end
endmodule

// File: rtl/shadow_wr_arb.sv
module shadow_wr_arb
    import shadow_pkg::*;
#(
    parameter int LEN = 10
) (
    input  port_mode_t      mode,
    input  logic            host_wr,
    input  logic [LEN:0]    host_addr,
    input  byte_t           host_wdata,
    input  lane_wr_t        snp,
    input  logic [LEN-1:0]  snp_idx,
    output lane_wr_t        wr,
    output logic [LEN-1:0]  wr_idx
);
    // restore writes win; a colliding snooped write is dropped
    always_comb begin
        if (mode == PORT_RESTORE && host_wr) begin
            wr.en   = lane_onehot(host_addr[0]);
            wr.data = {LANES{host_wdata}};
            wr_idx  = host_addr[LEN:1];
        end else begin
            wr     = snp;
            wr_idx = snp_idx;
        end
    end
endmodule

// File: rtl/shadow_lane_ram.sv
module shadow_lane_ram
    import shadow_pkg::*;
#(
    parameter int LEN = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [LEN-1:0]  widx,
    input  byte_t           wdata,
    input  logic            re,
    input  logic [LEN-1:0]  ridx,
    output byte_t           rdata
);
    localparam int DEPTH = 1 << LEN;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // read-first: a same-cycle write is seen on the next read
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[ridx];
    end
endmodule

// File: rtl/sdram_shadow_dump.sv
module sdram_shadow_dump
    import shadow_pkg::*;
#(
    parameter int          AW   = 22,
    parameter int          LEN  = 10,
    parameter int unsigned BASE = 'h10_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sd_we,
    input  logic [AW-1:0]           sd_waddr,
    input  logic [LANES*BYTE_W-1:0] sd_wdata,
    input  logic [LANES-1:0]        sd_wbe,
    input  logic                    save_act,
    input  logic                    dl_active,
    input  logic                    host_wr,
    input  logic [LEN:0]            host_addr,
    input  logic [BYTE_W-1:0]       host_wdata,
    output logic [BYTE_W-1:0]       dump_data
);
    port_mode_t             mode;
    logic                   rd_en;
    lane_wr_t               snp;
    logic [LEN-1:0]         snp_idx;
    lane_wr_t               wr_cmd;
    logic [LEN-1:0]         wr_idx;
    logic [LANES-1:0]       lane_we;
    byte_t [LANES-1:0]      lane_q;
    logic                   sel_q;

    assign mode    = port_mode(save_act, dl_active);
    assign rd_en   = (mode == PORT_DUMP);
    assign lane_we = wr_cmd.en;

    shadow_snoop #(.AW(AW), .LEN(LEN), .BASE(BASE)) u_snoop (
        .sd_we    (sd_we),
        .sd_waddr (sd_waddr),
        .sd_wdata (sd_wdata),
        .sd_wbe   (sd_wbe),
        .snp      (snp),
        .snp_idx  (snp_idx)
    );

    shadow_wr_arb #(.LEN(LEN)) u_arb (
        .mode       (mode),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .snp        (snp),
        .snp_idx    (snp_idx),
        .wr         (wr_cmd),
        .wr_idx     (wr_idx)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        shadow_lane_ram #(.LEN(LEN)) u_ram (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_cmd.en[l]),
            .widx  (wr_idx),
            .wdata (wr_cmd.data[l]),
            .re    (rd_en),
            .ridx  (host_addr[LEN:1]),
            .rdata (lane_q[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        sel_q <= 1'b0;
        else if (rd_en) sel_q <= host_addr[0];
    end

    assign dump_data = pick_lane(lane_q, sel_q);
endmodule

// File: rtl/shadow_dump_checker.sv
module shadow_dump_checker #(
    parameter int          AW   = 22,
    parameter int          LEN  = 10,
    parameter int unsigned BASE = 'h10_0000
) (
    input logic           clk,
    input logic           rst,
    input logic           sd_we,
    input logic [AW-1:0]  sd_waddr,
    input logic [1:0]     sd_wbe,
    input logic           save_act,
    input logic           dl_active,
    input logic           host_wr,
    input logic [LEN:0]   host_addr,
    input logic [7:0]     dump_data,
    input logic [1:0]     lane_we
);
    localparam int HW = AW - LEN;
    localparam logic [HW-1:0] BASE_HI = HW'(BASE >> LEN);

    logic restore_wr;
    logic in_win;
    logic reading;

    assign restore_wr = save_act && dl_active && host_wr;
    assign in_win     = (sd_waddr[AW-1:LEN] == BASE_HI);
    assign reading    = save_act && !dl_active;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dump_data == 8'h00);

    assert_lane_enables_R3: assert property (@(posedge clk) disable iff (rst)
        (sd_we && in_win && !restore_wr) |-> lane_we == sd_wbe);

    assert_outside_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        ((!sd_we || !in_win) && !restore_wr) |-> lane_we == 2'b00);

    assert_restore_wins_R7: assert property (@(posedge clk) disable iff (rst)
        restore_wr |-> ($countones(lane_we) == 1 && lane_we[host_addr[0]]));

    // also covers the hold during restore (R6)
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!reading)) |-> $stable(dump_data));
endmodule

bind sdram_shadow_dump shadow_dump_checker #(.AW(AW), .LEN(LEN), .BASE(BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_we     (sd_we),
    .sd_waddr  (sd_waddr),
    .sd_wbe    (sd_wbe),
    .save_act  (save_act),
    .dl_active (dl_active),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .dump_data (dump_data),
    .lane_we   (lane_we)
);

// File: tb/sdram_shadow_dump_test.sv
`timescale 1ns/1ps
module sdram_shadow_dump_test;
    localparam int          AW   = 22;
    localparam int          LEN  = 10;
    localparam int unsigned BASE = 'h10_0000;
    localparam int          WORDS = 1 << LEN;
    localparam int          BYTES = 2 * WORDS;

    typedef struct packed {
        logic          we;
        logic [21:0]   a;
        logic [15:0]   d;
        logic [1:0]    be;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 22'h100000, 16'hA55A, 2'b11},
        '{1'b1, 22'h1003FF, 16'h1234, 2'b01},
        '{1'b1, 22'h100200, 16'hBEEF, 2'b10},
        '{1'b1, 22'h0FFFFF, 16'hDEAD, 2'b11},
        '{1'b1, 22'h100400, 16'hCAFE, 2'b11},
        '{1'b1, 22'h100005, 16'h7788, 2'b00},
        '{1'b0, 22'h100010, 16'h1357, 2'b11},
        '{1'b1, 22'h100001, 16'h9ABC, 2'b11},
        '{1'b1, 22'h3003FF, 16'h4444, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        sd_we;
    logic [21:0] sd_waddr;
    logic [15:0] sd_wdata;
    logic [1:0]  sd_wbe;
    logic        save_act;
    logic        dl_active;
    logic        host_wr;
    logic [10:0] host_addr;
    logic [7:0]  host_wdata;
    logic [7:0]  dump_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [WORDS];

    always #2.5 clk = ~clk;

    sdram_shadow_dump #(.AW(AW), .LEN(LEN), .BASE(BASE)) uut (
        .clk(clk), .rst(rst), .sd_we(sd_we), .sd_waddr(sd_waddr),
        .sd_wdata(sd_wdata), .sd_wbe(sd_wbe), .save_act(save_act),
        .dl_active(dl_active), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .dump_data(dump_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int b);
        return b[0] ? model[b >> 1][15:8] : model[b >> 1][7:0];
    endfunction

    function automatic logic [7:0] fill(input int b);
        return 8'((b * 13 + 7) ^ (b >> 8));
    endfunction

    task automatic read_at(input string req, input int b);
        save_act  = 1'b1;
        dl_active = 1'b0;
        host_wr   = 1'b0;
        host_addr = 11'(b);
        tick();
        chk(req, dump_data, mbyte(b));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; sd_we = 1'b0; sd_waddr = '0; sd_wdata = '0; sd_wbe = '0;
        save_act = 1'b0; dl_active = 1'b0; host_wr = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset value", dump_data, 8'h00);

        // restore fills the whole window
        save_act = 1'b1; dl_active = 1'b1; host_wr = 1'b1;
        for (int b = 0; b < BYTES; b++) begin
            host_addr  = 11'(b);
            host_wdata = fill(b);
            tick();
            if (b[0]) model[b >> 1][15:8] = fill(b);
            else      model[b >> 1][7:0]  = fill(b);
            if (b == 0) chk("R6 no readout during restore", dump_data, 8'h00);
        end
        host_wr = 1'b0;

        read_at("R5 readout after restore", 3);
        read_at("R6 restored high byte", 1023);

        // idle hold
        save_act = 1'b0; host_addr = 11'd4;
        tick(); tick();
        chk("R8 hold while idle", dump_data, mbyte(1023));
        save_act = 1'b1; dl_active = 1'b1; host_addr = 11'd6;
        tick();
        chk("R6 hold in restore mode", dump_data, mbyte(1023));
        dl_active = 1'b0;

        // table of snooped writes
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VEC[i];
            automatic logic inwin = (v.a >= 22'(BASE)) && (v.a < 22'(BASE + WORDS));
            automatic int idx = int'(v.a[LEN-1:0]);
            automatic string tag = (!v.we || !inwin) ? "R4" : (v.be != 2'b11) ? "R3" : "R2";
            save_act = 1'b0;
            sd_we = v.we; sd_waddr = v.a; sd_wdata = v.d; sd_wbe = v.be;
            tick();
            sd_we = 1'b0;
            if (v.we && inwin) begin
                if (v.be[0]) model[idx][7:0]  = v.d[7:0];
                if (v.be[1]) model[idx][15:8] = v.d[15:8];
            end
            read_at(tag, 2 * idx);
            read_at(tag, 2 * idx + 1);
        end

        // restore write collides with snooped write to the same word
        save_act = 1'b1; dl_active = 1'b1; host_wr = 1'b1;
        host_addr = {10'd5, 1'b0}; host_wdata = 8'h3C;
        sd_we = 1'b1; sd_waddr = 22'(BASE + 5); sd_wdata = 16'hF00F; sd_wbe = 2'b11;
        tick();
        sd_we = 1'b0; host_wr = 1'b0;
        model[5][7:0] = 8'h3C;
        read_at("R7 restore byte kept", 10);
        read_at("R7 snoop dropped", 11);

        // readout collides with snooped write to the word being read
        read_at("R9 before collision", 14);
        sd_we = 1'b1; sd_waddr = 22'(BASE + 7); sd_wdata = 16'h005A; sd_wbe = 2'b01;
        tick();
        sd_we = 1'b0;
        chk("R9 old byte first", dump_data, mbyte(14));
        model[7][7:0] = 8'h5A;
        tick();
        chk("R9 new byte next", dump_data, 8'h5A);

        // strobe-less readout, new address every cycle
        for (int b = 0; b < BYTES; b++) read_at("R5 full readout", b);

        summary();
        $finish;
    end
endmodule